// File: doc/BRIEF.md
# Write-Protected SRAM Access Controller

This block sits in front of a byte-wide static memory of 32K locations. A host drives it through active-low chip select, write strobe and output enable pins, a 15-bit address and a data bus. The bus is split into an input byte, an output byte and a drive-enable flag for the pad ring. The block turns those pins into read cycles and write commits on an internal register array. A supervisor supplies a power-good flag. While that flag is low the block is write-protected: every control pin is ignored, nothing is written and the output driver is released.

All pins are sampled on the rising clock edge by one register stage. The decode works on those samples. The write strobe is the AND of the sampled chip select and write enable, so either may fall first. The byte is committed on the first sample in which either pin has returned high. The address and data held in the last active strobe sample are used. The write enable overrides the output enable. The bus is a pin interface with no back-pressure, and the host owns all cycle pacing.

The storage holds 2**MEM_AW bytes (default 1024), indexed by the low address bits.

Top module: `sram_fe_top`

## Requirements
- R1: When the sample of ce_n=0, oe_n=0, we_n=1 and pwr_ok=1 is taken on clock edge k, dq_oe is 1 after edge k+1 and dq_out holds the stored byte at the sampled address. Otherwise dq_oe is 0 after edge k+1.
- R2: The address port is 15 bits wide. The array holds 2**MEM_AW bytes, indexed by addr[MEM_AW-1:0]. Addresses that differ only above bit MEM_AW-1 reach the same byte; with the default MEM_AW=10, addr and addr+1024 alias.
- R3: A write strobe is active in every sample where ce_n=0 and we_n=0. The byte commits once the strobe ends, on the first sample where either pin is 1. This holds whether ce_n or we_n fell first and whichever rises first.
- R4: The committed address and byte are those sampled in the last sample in which the strobe was active. Earlier data values inside the same strobe are discarded.
- R5: A sample with we_n=0 forces dq_oe to 0 one edge later, even when ce_n and oe_n are both 0.
- R6: While pwr_ok is sampled 0, dq_oe is 0 one edge later, no write strobe is recognised and the array keeps its contents.
- R7: A write strobe that sees pwr_ok sampled 0 at any point never commits. This holds even if power returns before ce_n or we_n rises. A new strobe needs ce_n or we_n to go high first.
- R8: While rst_n is 0 and after its release, dq_oe is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Power-good flag from the supervisor, 1 = supply in tolerance |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Byte address |
| dq_in | input | 8 | Data bus as seen by the input pad |
| dq_out | output | 8 | Byte driven toward the output pad |
| dq_oe | output | 1 | Output pad drive enable, 0 = high impedance |

## Verification
Each pin change is sampled on the next rising edge. Read data and the drive flag follow on the edge after that, so any output result is due two edges after the stimulus. A write lands in the array two edges after the strobe ends. The bench drives on falling edges and waits three falling edges before each sample, which clears both latencies with margin. It reads back written bytes only after the strobe has ended and that delay has passed. The protection and abort scenarios check the array through a normal read after power is restored. This shows that the old byte survived.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
  // Control pins after sampling, converted to active-high.
  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
  } ctl_t;
endpackage

// File: rtl/sram_fe_sampler.sv
module sram_fe_sampler
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output ctl_t              ctl_q,
  output logic              pwr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      pwr_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ctl_q.sel <= ~ce_n;
      ctl_q.wr  <= ~we_n;
      ctl_q.rd  <= ~oe_n;
      pwr_q     <= pwr_ok;
      addr_q    <= addr;
      data_q    <= dq_in;
    end
  end
endmodule

// File: rtl/sram_fe_wrctl.sv
module sram_fe_wrctl
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl_q,
  input  logic              pwr_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  output logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic raw_strobe;
  logic live_strobe;
  logic blocked;
  logic armed;

  assign raw_strobe  = ctl_q.sel & ctl_q.wr;
  assign live_strobe = raw_strobe & pwr_q & ~blocked;
  // Strobe ended this sample with power still good: write it.
  assign commit      = armed & ~live_strobe & pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked <= 1'b0;
      armed   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      // A strobe touched by a power drop stays dead until it ends.
      blocked <= raw_strobe & (blocked | ~pwr_q);
      armed   <= live_strobe;
      if (live_strobe) begin
        wr_addr <= addr_q;
        wr_data <= data_q;
      end
    end
  end
endmodule

// File: rtl/sram_fe_store.sv
module sram_fe_store #(
  parameter int MEM_AW = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_drive <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_drive <= rd_en;
      rd_data  <= rd_en ? mem[rd_idx] : '0;
    end
  end
endmodule

// File: rtl/sram_fe_top.sv
module sram_fe_top
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  ctl_t              ctl_q;
  logic              pwr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              read_en;

  sram_fe_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in),
    .ctl_q(ctl_q), .pwr_q(pwr_q), .addr_q(addr_q), .data_q(data_q)
  );

  sram_fe_wrctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .pwr_q(pwr_q),
    .addr_q(addr_q), .data_q(data_q),
    .commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Write enable wins over output enable; power-good gates everything.
  assign read_en = pwr_q & ctl_q.sel & ctl_q.rd & ~ctl_q.wr;

  sram_fe_store #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_commit), .wr_idx(wr_addr[MEM_AW-1:0]), .wr_data(wr_data),
    .rd_en(read_en), .rd_idx(addr_q[MEM_AW-1:0]),
    .rd_data(dq_out), .rd_drive(dq_oe)
  );
endmodule

// File: rtl/sram_fe_chk.sv
module sram_fe_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic commit,
  input logic pwr_q
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && dq_oe) |-> ($past(ce_n, 2) == 1'b0 && $past(oe_n, 2) == 1'b0)); // R1
  AST_WE_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && dq_oe) |-> $past(we_n, 2)); // R5
  AST_PROT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && dq_oe) |-> $past(pwr_ok, 2)); // R6
  AST_COMMIT_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && commit) |-> ($past(pwr_ok) && pwr_q)); // R7
  AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && commit) |-> ($past(!ce_n && !we_n, 2) && $past(ce_n || we_n, 1))); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> (!dq_oe && !commit)); // R8
endmodule

bind sram_fe_top sram_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
  .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .dq_oe(dq_oe), .commit(wr_commit), .pwr_q(pwr_q)
);

// File: tb/sim_sram_fe_top.sv
module sim_sram_fe_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_ok = 1'b0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sram_fe_top u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input bit ce_first);
    @(negedge clk);
    addr = a; dq_in = d; oe_n = 1'b1;
    if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
    @(negedge clk);
    if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
    repeat (2) @(negedge clk);
    if (ce_first) we_n = 1'b1; else ce_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    settle();
  endtask

  task automatic read_check(input logic [14:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    settle();
    chk(dq_oe == 1'b1, tag, dq_oe, 1);
    chk(dq_out == exp, tag, dq_out, exp);
    ce_n = 1'b1; oe_n = 1'b1;
    settle();
    chk(dq_oe == 1'b0, tag, dq_oe, 0);
  endtask

  task automatic sc_reset();
    repeat (3) @(negedge clk);
    chk(dq_oe == 1'b0, "R8 in reset", dq_oe, 0);
    rst_n = 1'b1; pwr_ok = 1'b1;
    settle();
    chk(dq_oe == 1'b0, "R8 after reset", dq_oe, 0);
  endtask

  task automatic sc_orders();
    do_write(15'h0011, 8'hA5, 1'b1);
    read_check(15'h0011, 8'hA5, "R3 ce first");
    do_write(15'h0022, 8'h5A, 1'b0);
    read_check(15'h0022, 8'h5A, "R3 we first");
    // R1: read with oe_n high keeps driver off
    @(negedge clk);
    addr = 15'h0011; ce_n = 1'b0; oe_n = 1'b1;
    settle();
    chk(dq_oe == 1'b0, "R1 oe high", dq_oe, 0);
    ce_n = 1'b1;
    settle();
  endtask

  task automatic sc_last_data();
    @(negedge clk);
    addr = 15'h0033; dq_in = 8'h01; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    dq_in = 8'hC3;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
    settle();
    read_check(15'h0033, 8'hC3, "R4 last data");
  endtask

  task automatic sc_alias();
    do_write(15'h0044 + 15'd1024, 8'h77, 1'b1);
    read_check(15'h0044, 8'h77, "R2 alias");
    read_check(15'h7C44, 8'h77, "R2 high bits");
  endtask

  task automatic sc_we_override();
    do_write(15'h0055, 8'h10, 1'b1);
    @(negedge clk);
    addr = 15'h0055; dq_in = 8'h9E; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    settle();
    chk(dq_oe == 1'b1, "R5 driving", dq_oe, 1);
    we_n = 1'b0;
    settle();
    chk(dq_oe == 1'b0, "R5 we_n low", dq_oe, 0);
    we_n = 1'b1;
    settle();
    chk(dq_oe == 1'b1 && dq_out == 8'h9E, "R5 write then read", dq_out, 8'h9E);
    ce_n = 1'b1; oe_n = 1'b1;
    settle();
  endtask

  task automatic sc_protect();
    do_write(15'h0066, 8'h3C, 1'b0);
    @(negedge clk);
    pwr_ok = 1'b0;
    addr = 15'h0066; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    settle();
    chk(dq_oe == 1'b0, "R6 read blocked", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    do_write(15'h0066, 8'hEE, 1'b1);
    do_write(15'h0066, 8'hDD, 1'b0);
    @(negedge clk);
    pwr_ok = 1'b1;
    settle();
    read_check(15'h0066, 8'h3C, "R6 no write");
  endtask

  task automatic sc_abort();
    do_write(15'h0077, 8'h42, 1'b1);
    @(negedge clk);
    addr = 15'h0077; dq_in = 8'hBB; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    pwr_ok = 1'b0;
    repeat (2) @(negedge clk);
    pwr_ok = 1'b1;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
    settle();
    read_check(15'h0077, 8'h42, "R7 abort");
  endtask

  initial begin
    sc_reset();
    sc_orders();
    sc_last_data();
    sc_alias();
    sc_we_override();
    sc_protect();
    sc_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule